// File: doc/BRIEF.md
# Byte-Lane PCI Initiator Bridge

This block lets a processor run single-beat PCI transactions through four memory-mapped registers. Three kinds of transaction are supported: I/O read, I/O write, and configuration read/write. Any single byte lane can be accessed, which a word-only processor port cannot do. Software loads a target address and, for writes, a data word. It then writes a command code to the control register. The bridge runs one address phase and one data phase on the bus, then returns to idle. Software polls an idle flag in the control register and then reads the captured data word.

Two control bits drive the IDSEL lines of two attached devices. While either bit is set, the command is turned into its configuration-space form. A further control bit drives the bus reset output directly. The bridge assumes it already owns the bus: it does no arbitration, no bursts, no memory-space commands and no parity.

A target that does not claim the cycle in time ends the transaction as a master abort. A target stop without ready also ends it. In both cases a sticky error bit is raised.

Top module: `pci_lane_initiator`

## Requirements
- R1: Registers sit at byte offsets 0x00000 (control), 0x08000 (address), 0x10000 (write data) and 0x18000 (read data, read-only). A write reaches a register only when the low 15 offset bits are zero. The address and write-data registers read back what was written.
- R2: Writing the control register with bits [3:0] equal to 0x2 (I/O read) or 0x3 (I/O write) starts a transaction. The cycle after the write is the address phase: FRAME# is low for that one cycle, the address is driven on AD, and the command is driven on C/BE#. The data phase follows, with IRDY# low until DEVSEL# and TRDY# are both sampled low.
- R3: For I/O commands the data-phase C/BE# enables exactly one lane, chosen by address bits [1:0]: lane n is driven low and the other lanes high.
- R4: Control bit 12 drives IDSEL[0] and bit 13 drives IDSEL[1]. While either bit is set, the bus command becomes 0xA for a read or 0xB for a write, and all four C/BE# lanes are low in the data phase.
- R5: On writes, the write-data register is driven on AD with the output enable high during the data phase. On reads, AD is not driven, and the AD value sampled together with TRDY# is stored in the read-data register.
- R6: If DEVSEL# has not been sampled low by the 5th data-phase clock, the transaction ends (master abort). A read then returns 0xFFFFFFFF and control bit 17 (error) is set. The error bit is cleared when the next transaction starts.
- R7: A claimed cycle that samples STOP# low with TRDY# high ends at once. It sets the error bit, and a read returns 0xFFFFFFFF.
- R8: Control bit 16 reads 1 only when idle. A transaction keeps it at 0 for L+2 cycles: one address cycle, L data cycles and one turnaround cycle. L is the data-phase clock at which the target responds, or 5 on a master abort.
- R9: All register writes made while the bridge is busy are ignored. This covers a new command, which issues no second address phase.
- R10: Starting a transaction clears the read-data register to zero.
- R11: Control bit 15 drives the bus reset output, which is active low (pci_rst_n equals the inverse of the bit). Writing any command code other than 0x2 or 0x3 updates bits 12, 13 and 15 and starts no transaction.
- R12: After reset the control register reads 0x00010000 (idle only). FRAME# and IRDY# are high, AD is not driven, IDSEL is 0 and the bus reset output is high.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock shared by the processor side and the bus side |
| rst_n | input | 1 | Asynchronous active-low reset |
| cpu_we | input | 1 | Register write strobe |
| cpu_addr | input | 17 | Register byte offset |
| cpu_wdata | input | 32 | Register write data |
| cpu_rdata | output | 32 | Register read data, combinational from cpu_addr |
| pci_ad_o | output | 32 | Address/data driven toward the bus |
| pci_ad_oe | output | 1 | Output enable for pci_ad_o |
| pci_ad_i | input | 32 | Address/data sampled from the bus |
| pci_cbe_n | output | 4 | Command / byte enables, active low |
| pci_frame_n | output | 1 | FRAME#, active low |
| pci_irdy_n | output | 1 | IRDY#, active low |
| pci_trdy_n | input | 1 | TRDY#, active low |
| pci_devsel_n | input | 1 | DEVSEL#, active low |
| pci_stop_n | input | 1 | STOP#, active low |
| pci_idsel | output | 2 | Select lines of the two configurable devices |
| pci_rst_n | output | 1 | Bus reset output, active low |

## Verification
The bench builds the block with its default parameters: four byte lanes, a five-clock DEVSEL# window and 17 offset bits. With these values the bench can sweep every lane, every response latency inside the window, and both the read and write directions. It can also drive every IDSEL combination through a behavioural target. The abort path, the stop path, the exact busy length and writes made while busy are all observed at the ports.

// File: rtl/pcib_pkg.sv
`timescale 1ns/1ps
package pcib_pkg;

  typedef enum logic [1:0] {
    SQ_IDLE = 2'd0,
    SQ_ADDR = 2'd1,
    SQ_DATA = 2'd2,
    SQ_TURN = 2'd3
  } sq_state_t;

  // register select, upper two offset bits
  localparam logic [1:0] RSEL_CTRL = 2'd0;
  localparam logic [1:0] RSEL_ADDR = 2'd1;
  localparam logic [1:0] RSEL_WDAT = 2'd2;
  localparam logic [1:0] RSEL_RDAT = 2'd3;

  // bus commands
  localparam logic [3:0] BC_IO_RD  = 4'h2;
  localparam logic [3:0] BC_IO_WR  = 4'h3;
  localparam logic [3:0] BC_CFG_RD = 4'hA;
  localparam logic [3:0] BC_CFG_WR = 4'hB;

  // control field positions
  localparam int CB_SELA = 12;
  localparam int CB_SELB = 13;
  localparam int CB_RST  = 15;
  localparam int CB_IDLE = 16;
  localparam int CB_ERR  = 17;

endpackage

// File: rtl/pcib_lanes.sv
`timescale 1ns/1ps
module pcib_lanes #(
  parameter int LANES = 4,
  parameter int LW    = $clog2(LANES)
) (
  input  logic [LW-1:0]    lane,
  input  logic             cfg,
  output logic [LANES-1:0] be_n
);
  for (genvar i = 0; i < LANES; i++) begin : g_lane
    assign be_n[i] = cfg ? 1'b0 : (lane != LW'(i));
  end
endmodule

// File: rtl/pcib_seq.sv
`timescale 1ns/1ps
module pcib_seq
  import pcib_pkg::*;
#(
  parameter int DEVSEL_WAIT = 5
) (
  input  logic      clk,
  input  logic      rst_n,
  input  logic      start,
  input  logic      trdy_n,
  input  logic      devsel_n,
  input  logic      stop_n,
  output sq_state_t state,
  output logic      fin_valid,
  output logic      fin_ok
);
  localparam int CNT_W = $clog2(DEVSEL_WAIT + 1);
  localparam logic [CNT_W-1:0] CNT_LIM = CNT_W'(DEVSEL_WAIT);

  sq_state_t        st_q, st_d;
  logic [CNT_W-1:0] cnt_q, cnt_d;
  logic             seen_q, seen_d;
  logic             seen_now;
  logic             cnt_en;

  assign seen_now = seen_q | ~devsel_n;
  assign cnt_en   = (st_q == SQ_ADDR) || (st_q == SQ_DATA);

  always_comb begin
    st_d      = st_q;
    cnt_d     = cnt_q;
    seen_d    = seen_q;
    fin_valid = 1'b0;
    fin_ok    = 1'b0;
    case (st_q)
      SQ_IDLE: if (start) st_d = SQ_ADDR;
      SQ_ADDR: begin
        st_d   = SQ_DATA;
        cnt_d  = CNT_W'(1);
        seen_d = 1'b0;
      end
      SQ_DATA: begin
        seen_d = seen_now;
        if (cnt_q != CNT_LIM) cnt_d = cnt_q + CNT_W'(1);
        if (seen_now && !trdy_n) begin
          fin_valid = 1'b1;
          fin_ok    = 1'b1;
          st_d      = SQ_TURN;
        end else if (seen_now && !stop_n) begin
          fin_valid = 1'b1;
          st_d      = SQ_TURN;
        end else if (!seen_now && cnt_q == CNT_LIM) begin
          fin_valid = 1'b1;
          st_d      = SQ_TURN;
        end
      end
      default: st_d = SQ_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q   <= SQ_IDLE;
      cnt_q  <= '0;
      seen_q <= 1'b0;
    end else begin
      st_q <= st_d;
      if (cnt_en) begin
        cnt_q  <= cnt_d;
        seen_q <= seen_d;
      end
    end
  end

  assign state = st_q;
endmodule

// File: rtl/pcib_regs.sv
`timescale 1ns/1ps
module pcib_regs
  import pcib_pkg::*;
#(
  parameter int LANES = 4,
  parameter int OFS_W = 17
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               cpu_we,
  input  logic [OFS_W-1:0]   cpu_addr,
  input  logic [8*LANES-1:0] cpu_wdata,
  output logic [8*LANES-1:0] cpu_rdata,
  input  logic               idle,
  input  logic               fin_valid,
  input  logic               fin_ok,
  input  logic [8*LANES-1:0] bus_rdata,
  output logic               start,
  output logic [3:0]         code,
  output logic               sel_a,
  output logic               sel_b,
  output logic               rst_bit,
  output logic [8*LANES-1:0] addr_q,
  output logic [8*LANES-1:0] wdat_q
);
  localparam int DW     = 8 * LANES;
  localparam int SEL_LO = OFS_W - 2;

  logic [1:0]    rsel;
  logic          hit, code_ok, is_rd;
  logic [3:0]    code_q, code_d;
  logic          sela_q, sela_d, selb_q, selb_d, rst_q, rst_d;
  logic          err_q, err_d;
  logic [DW-1:0] addr_d, wdat_d, rdat_q, rdat_d;
  logic          ctrl_unused;

  assign rsel    = cpu_addr[OFS_W-1:SEL_LO];
  assign hit     = cpu_we && idle && (cpu_addr[SEL_LO-1:0] == '0);
  assign code_ok = (cpu_wdata[3:0] == BC_IO_RD) || (cpu_wdata[3:0] == BC_IO_WR);
  assign start   = hit && (rsel == RSEL_CTRL) && code_ok;
  assign is_rd   = (code_q == BC_IO_RD);
  assign ctrl_unused = ^{cpu_wdata[DW-1:CB_RST+1], cpu_wdata[CB_RST-1:CB_SELB+1],
                         cpu_wdata[CB_SELA-1:4]};

  always_comb begin
    code_d = code_q;
    sela_d = sela_q;
    selb_d = selb_q;
    rst_d  = rst_q;
    addr_d = addr_q;
    wdat_d = wdat_q;
    err_d  = err_q;
    rdat_d = rdat_q;
    if (hit) begin
      case (rsel)
        RSEL_CTRL: begin
          code_d = cpu_wdata[3:0];
          sela_d = cpu_wdata[CB_SELA];
          selb_d = cpu_wdata[CB_SELB];
          rst_d  = cpu_wdata[CB_RST];
        end
        RSEL_ADDR: addr_d = cpu_wdata;
        RSEL_WDAT: wdat_d = cpu_wdata;
        default: ;
      endcase
    end
    if (start) begin
      err_d  = 1'b0;
      rdat_d = '0;
    end else if (fin_valid) begin
      if (!fin_ok) err_d = 1'b1;
      if (is_rd) rdat_d = fin_ok ? bus_rdata : '1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      code_q <= '0;
      sela_q <= 1'b0;
      selb_q <= 1'b0;
      rst_q  <= 1'b0;
      addr_q <= '0;
      wdat_q <= '0;
      err_q  <= 1'b0;
      rdat_q <= '0;
    end else begin
      if (hit) begin
        code_q <= code_d;
        sela_q <= sela_d;
        selb_q <= selb_d;
        rst_q  <= rst_d;
        addr_q <= addr_d;
        wdat_q <= wdat_d;
      end
      if (start || fin_valid) begin
        err_q  <= err_d;
        rdat_q <= rdat_d;
      end
    end
  end

  always_comb begin
    cpu_rdata = '0;
    case (rsel)
      RSEL_CTRL: begin
        cpu_rdata[3:0]     = code_q;
        cpu_rdata[CB_SELA] = sela_q;
        cpu_rdata[CB_SELB] = selb_q;
        cpu_rdata[CB_RST]  = rst_q;
        cpu_rdata[CB_IDLE] = idle;
        cpu_rdata[CB_ERR]  = err_q;
      end
      RSEL_ADDR: cpu_rdata = addr_q;
      RSEL_WDAT: cpu_rdata = wdat_q;
      default:   cpu_rdata = rdat_q;
    endcase
  end

  assign code    = code_q;
  assign sel_a   = sela_q;
  assign sel_b   = selb_q;
  assign rst_bit = rst_q;
endmodule

// File: rtl/pci_lane_initiator.sv
`timescale 1ns/1ps
module pci_lane_initiator
  import pcib_pkg::*;
#(
  parameter int LANES       = 4,
  parameter int DEVSEL_WAIT = 5,
  parameter int OFS_W       = 17
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               cpu_we,
  input  logic [OFS_W-1:0]   cpu_addr,
  input  logic [8*LANES-1:0] cpu_wdata,
  output logic [8*LANES-1:0] cpu_rdata,
  output logic [8*LANES-1:0] pci_ad_o,
  output logic               pci_ad_oe,
  input  logic [8*LANES-1:0] pci_ad_i,
  output logic [LANES-1:0]   pci_cbe_n,
  output logic               pci_frame_n,
  output logic               pci_irdy_n,
  input  logic               pci_trdy_n,
  input  logic               pci_devsel_n,
  input  logic               pci_stop_n,
  output logic [1:0]         pci_idsel,
  output logic               pci_rst_n
);
  localparam int DW = 8 * LANES;
  localparam int LW = $clog2(LANES);

  sq_state_t     state;
  logic          start, fin_valid, fin_ok, idle;
  logic [3:0]    code, bus_cmd;
  logic          sel_a, sel_b, rst_bit, cfg, is_wr;
  logic [DW-1:0] addr_q, wdat_q;
  logic [LANES-1:0] be_n;

  assign idle  = (state == SQ_IDLE);
  assign cfg   = sel_a | sel_b;
  assign is_wr = (code == BC_IO_WR);

  pcib_regs #(.LANES(LANES), .OFS_W(OFS_W)) u_regs (
    .clk(clk), .rst_n(rst_n), .cpu_we(cpu_we), .cpu_addr(cpu_addr),
    .cpu_wdata(cpu_wdata), .cpu_rdata(cpu_rdata), .idle(idle),
    .fin_valid(fin_valid), .fin_ok(fin_ok), .bus_rdata(pci_ad_i),
    .start(start), .code(code), .sel_a(sel_a), .sel_b(sel_b),
    .rst_bit(rst_bit), .addr_q(addr_q), .wdat_q(wdat_q)
  );

  pcib_seq #(.DEVSEL_WAIT(DEVSEL_WAIT)) u_seq (
    .clk(clk), .rst_n(rst_n), .start(start), .trdy_n(pci_trdy_n),
    .devsel_n(pci_devsel_n), .stop_n(pci_stop_n), .state(state),
    .fin_valid(fin_valid), .fin_ok(fin_ok)
  );

  pcib_lanes #(.LANES(LANES)) u_lanes (
    .lane(addr_q[LW-1:0]), .cfg(cfg), .be_n(be_n)
  );

  always_comb begin
    if (cfg) bus_cmd = is_wr ? BC_CFG_WR : BC_CFG_RD;
    else     bus_cmd = code;
  end

  always_comb begin
    pci_frame_n = (state != SQ_ADDR);
    pci_irdy_n  = (state != SQ_DATA);
    pci_ad_oe   = 1'b0;
    pci_ad_o    = '0;
    pci_cbe_n   = '1;
    case (state)
      SQ_ADDR: begin
        pci_ad_oe = 1'b1;
        pci_ad_o  = addr_q;
        pci_cbe_n = LANES'(bus_cmd);
      end
      SQ_DATA: begin
        pci_ad_oe = is_wr;
        pci_ad_o  = is_wr ? wdat_q : '0;
        pci_cbe_n = be_n;
      end
      default: ;
    endcase
  end

  assign pci_idsel = {sel_b, sel_a};
  assign pci_rst_n = ~rst_bit;
endmodule

// File: rtl/pcib_chk.sv
`timescale 1ns/1ps
module pcib_chk #(
  parameter int LANES       = 4,
  parameter int DEVSEL_WAIT = 5
) (
  input logic             clk,
  input logic             rst_n,
  input logic             pci_frame_n,
  input logic             pci_irdy_n,
  input logic             pci_trdy_n,
  input logic             pci_devsel_n,
  input logic             pci_ad_oe,
  input logic [LANES-1:0] pci_cbe_n,
  input logic [1:0]       pci_idsel
);
  localparam int CW = $clog2(DEVSEL_WAIT + 2);

  logic [CW-1:0] wcnt;
  logic          claimed;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wcnt    <= '0;
      claimed <= 1'b0;
    end else if (pci_irdy_n) begin
      wcnt    <= '0;
      claimed <= 1'b0;
    end else begin
      wcnt <= wcnt + CW'(1);
      if (!pci_devsel_n) claimed <= 1'b1;
    end
  end

  p_frame_single_r2: assert property (@(posedge clk) disable iff (!rst_n)
    !pci_frame_n |=> pci_frame_n);
  p_irdy_follows_r2: assert property (@(posedge clk) disable iff (!rst_n)
    !pci_frame_n |=> !pci_irdy_n);
  p_addr_driven_r2: assert property (@(posedge clk) disable iff (!rst_n)
    !pci_frame_n |-> pci_ad_oe);
  p_release_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (!pci_irdy_n && !pci_trdy_n && !pci_devsel_n) |=> (pci_irdy_n && pci_frame_n));
  p_one_lane_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (!pci_irdy_n && pci_idsel == 2'b00) |-> ($countones(~pci_cbe_n) == 1));
  p_cfg_lanes_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (!pci_irdy_n && pci_idsel != 2'b00) |-> (pci_cbe_n == '0));
  p_devsel_window_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (!pci_irdy_n && !claimed) |-> (wcnt < CW'(DEVSEL_WAIT)));
  p_turnaround_r8: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(pci_irdy_n) |=> pci_frame_n);
endmodule

bind pci_lane_initiator pcib_chk #(.LANES(LANES), .DEVSEL_WAIT(DEVSEL_WAIT)) u_chk (
  .clk(clk), .rst_n(rst_n), .pci_frame_n(pci_frame_n), .pci_irdy_n(pci_irdy_n),
  .pci_trdy_n(pci_trdy_n), .pci_devsel_n(pci_devsel_n), .pci_ad_oe(pci_ad_oe),
  .pci_cbe_n(pci_cbe_n), .pci_idsel(pci_idsel)
);

// File: tb/pci_lane_initiator_tb.sv
`timescale 1ns/1ps
module pci_lane_initiator_tb;
  localparam logic [16:0] O_CTRL = 17'h00000, O_ADDR = 17'h08000,
                          O_WDAT = 17'h10000, O_RDAT = 17'h18000;

  logic        clk, rst_n, cpu_we;
  logic [16:0] cpu_addr;
  logic [31:0] cpu_wdata, cpu_rdata, pci_ad_o, pci_ad_i;
  logic        pci_ad_oe, pci_frame_n, pci_irdy_n, pci_trdy_n, pci_devsel_n, pci_stop_n;
  logic [3:0]  pci_cbe_n;
  logic [1:0]  pci_idsel;
  logic        pci_rst_n;

  int total = 0, bad = 0;
  int t_lat = 1, t_mode = 0, dcnt = 0, frames = 0;
  logic [31:0] t_pat = 32'h0;
  logic [31:0] cap_addr, cap_wd;
  logic [3:0]  cap_cmd, cap_be;
  logic        cap_oe;

  pci_lane_initiator u_dut (
    .clk(clk), .rst_n(rst_n), .cpu_we(cpu_we), .cpu_addr(cpu_addr),
    .cpu_wdata(cpu_wdata), .cpu_rdata(cpu_rdata), .pci_ad_o(pci_ad_o),
    .pci_ad_oe(pci_ad_oe), .pci_ad_i(pci_ad_i), .pci_cbe_n(pci_cbe_n),
    .pci_frame_n(pci_frame_n), .pci_irdy_n(pci_irdy_n), .pci_trdy_n(pci_trdy_n),
    .pci_devsel_n(pci_devsel_n), .pci_stop_n(pci_stop_n), .pci_idsel(pci_idsel),
    .pci_rst_n(pci_rst_n)
  );

  initial clk = 1'b0;
  always #2.5 clk = ~clk;

  // behavioural target: mode 0 = ready, 1 = stop without ready, 2 = no claim
  always @(negedge clk) begin
    if (!pci_frame_n) begin
      cap_addr = pci_ad_o;
      cap_cmd  = pci_cbe_n;
      frames   = frames + 1;
    end
    if (!pci_irdy_n) begin
      dcnt = dcnt + 1;
      if (t_mode != 2 && dcnt >= t_lat) begin
        pci_devsel_n = 1'b0;
        pci_trdy_n   = (t_mode == 1);
        pci_stop_n   = (t_mode != 1);
        pci_ad_i     = t_pat;
        cap_be       = pci_cbe_n;
        cap_wd       = pci_ad_o;
        cap_oe       = pci_ad_oe;
      end
    end else begin
      dcnt = 0;
      pci_devsel_n = 1'b1;
      pci_trdy_n   = 1'b1;
      pci_stop_n   = 1'b1;
      pci_ad_i     = 32'h0;
    end
  end

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s act=%h exp=%h", tag, act, exp);
    end
  endtask

  task automatic wr(input logic [16:0] a, input logic [31:0] d);
    @(negedge clk);
    cpu_we = 1'b1; cpu_addr = a; cpu_wdata = d;
    @(negedge clk);
    cpu_we = 1'b0;
  endtask

  task automatic rd(input logic [16:0] a, output logic [31:0] d);
    cpu_addr = a;
    #0.5;
    d = cpu_rdata;
  endtask

  task automatic poll(output int busy);
    logic [31:0] c;
    busy = 0;
    rd(O_CTRL, c);
    while (!c[16] && busy < 100) begin
      busy++;
      @(negedge clk);
      rd(O_CTRL, c);
    end
  endtask

  task automatic run(input logic [31:0] ctrl, output int busy);
    wr(O_CTRL, ctrl);
    poll(busy);
  endtask

  initial begin
    #(5.0 * 150000);
    bad++;
    $display("FAIL watchdog expired act=running exp=done");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    logic [31:0] v, a, d, pat;
    int busy, f0;
    rst_n = 1'b0; cpu_we = 1'b0; cpu_addr = '0; cpu_wdata = '0;
    pci_devsel_n = 1'b1; pci_trdy_n = 1'b1; pci_stop_n = 1'b1; pci_ad_i = '0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);

    // R12 reset state
    rd(O_CTRL, v);
    chk("R12 ctrl after reset", v, 32'h0001_0000);
    chk("R12 frame/irdy/oe", {29'd0, pci_frame_n, pci_irdy_n, pci_ad_oe}, 32'd6);
    chk("R12 idsel and bus reset", {29'd0, pci_idsel, pci_rst_n}, 32'd1);

    // R11 bus reset bit, no transaction for other codes
    f0 = frames;
    wr(O_CTRL, 32'h0000_8000);
    chk("R11 reset output low", {31'd0, pci_rst_n}, 32'd0);
    rd(O_CTRL, v);
    chk("R11 ctrl readback idle", v, 32'h0001_8000);
    wr(O_CTRL, 32'h0000_3007);
    chk("R11 reset output released", {31'd0, pci_rst_n}, 32'd1);
    chk("R11 idsel follows bits", {30'd0, pci_idsel}, 32'd3);
    chk("R11 no address phase", frames, f0);

    // R1 register map
    wr(O_ADDR, 32'h1234_5678);
    rd(O_ADDR, v); chk("R1 address readback", v, 32'h1234_5678);
    wr(O_WDAT, 32'hCAFE_F00D);
    rd(O_WDAT, v); chk("R1 write-data readback", v, 32'hCAFE_F00D);
    wr(O_ADDR | 17'h4, 32'h0);
    rd(O_ADDR, v); chk("R1 misaligned offset ignored", v, 32'h1234_5678);

    // R2 R3 R5 R8 I/O sweep over lanes, directions, latencies
    for (int ln = 0; ln < 4; ln++) begin
      for (int w = 0; w < 2; w++) begin
        a   = 32'h0000_C100 + ln;
        d   = 32'h1111_1111 * (ln + 1) + w;
        pat = 32'hA500_0000 | (ln << 8) | w;
        t_lat = ln + 1 + w; t_mode = 0; t_pat = pat;
        wr(O_ADDR, a); wr(O_WDAT, d);
        run(w ? 32'h3 : 32'h2, busy);
        chk("R2 address phase command", {28'd0, cap_cmd}, w ? 32'h3 : 32'h2);
        chk("R2 address on AD", cap_addr, a);
        chk("R3 single lane enable", {28'd0, cap_be}, {28'd0, ~(4'b0001 << ln)});
        chk("R8 busy length", busy, t_lat + 2);
        if (w) begin
          chk("R5 write data driven", cap_wd, d);
          chk("R5 write oe", {31'd0, cap_oe}, 32'd1);
        end else begin
          chk("R5 read oe off", {31'd0, cap_oe}, 32'd0);
          rd(O_RDAT, v); chk("R5 read data captured", v, pat);
        end
        rd(O_CTRL, v); chk("R6 no error on success", {31'd0, v[17]}, 32'd0);
      end
    end

    // R4 configuration cycles
    for (int s = 1; s < 4; s++) begin
      for (int w = 0; w < 2; w++) begin
        t_lat = 2; t_mode = 0; t_pat = 32'h5A00_0000 + s * 16 + w;
        wr(O_ADDR, 32'h0000_0040);
        wr(O_WDAT, 32'h0BAD_0000 + s);
        run((s << 12) | (w ? 3 : 2), busy);
        chk("R4 config command", {28'd0, cap_cmd}, w ? 32'hB : 32'hA);
        chk("R4 all lanes enabled", {28'd0, cap_be}, 32'h0);
        chk("R4 idsel lines", {30'd0, pci_idsel}, s);
        if (w) chk("R5 config write data", cap_wd, 32'h0BAD_0000 + s);
        else begin
          rd(O_RDAT, v); chk("R5 config read data", v, 32'h5A00_0000 + s * 16);
        end
      end
    end

    // R6 master abort then error cleared
    t_mode = 2;
    wr(O_ADDR, 32'h0000_0202);
    run(32'h2, busy);
    chk("R6 abort busy length", busy, 7);
    rd(O_RDAT, v); chk("R6 abort read all ones", v, 32'hFFFF_FFFF);
    rd(O_CTRL, v); chk("R6 error bit set", {31'd0, v[17]}, 32'd1);
    t_mode = 0; t_lat = 1;
    run(32'h3, busy);
    rd(O_CTRL, v); chk("R6 error cleared by next start", {31'd0, v[17]}, 32'd0);
    chk("R8 fastest busy length", busy, 3);

    // R7 stop without ready
    t_mode = 1; t_lat = 3;
    run(32'h2, busy);
    chk("R7 stop busy length", busy, 5);
    rd(O_RDAT, v); chk("R7 stop read all ones", v, 32'hFFFF_FFFF);
    rd(O_CTRL, v); chk("R7 error bit set", {31'd0, v[17]}, 32'd1);

    // R10 read data cleared at start
    t_mode = 0; t_lat = 1; t_pat = 32'h7777_0001;
    run(32'h2, busy);
    rd(O_RDAT, v); chk("R10 prior read value", v, 32'h7777_0001);
    t_lat = 5;
    wr(O_CTRL, 32'h2);
    rd(O_RDAT, v); chk("R10 cleared at start", v, 32'h0);
    poll(busy);

    // R9 writes while busy ignored
    t_lat = 4;
    wr(O_ADDR, 32'h0000_00A0);
    f0 = frames;
    wr(O_CTRL, 32'h2);
    wr(O_ADDR, 32'h0000_0FFF);
    wr(O_CTRL, 32'h3);
    poll(busy);
    repeat (4) @(negedge clk);
    rd(O_ADDR, v); chk("R9 address kept", v, 32'h0000_00A0);
    rd(O_CTRL, v); chk("R9 command kept", {28'd0, v[3:0]}, 32'h2);
    chk("R9 single address phase", frames, f0 + 1);

    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule